// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit holds the transmit and receive word queues of an SPI controller. It also derives every status, interrupt and DMA-request signal from them. The bus side writes words into the transmit queue and reads words out of the receive queue. The serial shift engine drains the transmit queue and fills the receive queue. The storage depth is a parameter, either 32 or 64 words, and a single output flag tells software which depth was built.

Both queue occupancies are visible at all times. The unit keeps three sticky error flags: transmit overflow, receive overflow and receive underflow. Each flag can be cleared on its own, or all three together through a clear strobe. Two of the interrupt sources are not sticky but follow the live levels: transmit-empty and receive-threshold. The receive-threshold source fires only when the receive level is strictly greater than the programmed value, so software programs the wanted trigger count minus one. Dropping the enable input empties both queues immediately.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset both levels are 0, `status` is 5'b01100 and `rawIrq` is 5'b00001. The `status` bits are: bit 0 = `engBusy`, bit 1 = TX full, bit 2 = TX empty, bit 3 = RX empty, bit 4 = RX full.
- R2: Words leave each queue in the order they entered. `txLevel` and `rxLevel` give the stored word count one cycle after each accepted push or pop.
- R3: A bus push into a full TX queue (level = DEPTH) is dropped and sets `rawIrq` bit 1 (TX overflow). This holds even if the engine pops in the same cycle.
- R4: An engine push into a full RX queue is dropped and sets `rawIrq` bit 3 (RX overflow). A bus pop that delivers no word (RX empty or unit disabled) returns zero on `busPopData` and sets `rawIrq` bit 2 (RX underflow).
- R5: `rawIrq` bit 0 is high while `txLevel` is 0. `rawIrq` bit 4 is high while `rxLevel` > `rxThresh`.
- R6: `rawIrq` bits 1 to 3 stay set until cleared. The clear strobe `clrWrite` acts on `clrBits` as follows: bit 0 clears all three, bit 1 clears RX underflow, bit 2 clears RX overflow, bit 3 clears TX overflow. A new event in the same cycle as its clear leaves the flag set.
- R7: `maskedIrq` equals `rawIrq` AND `intMask`. `irq` is high when any bit of `maskedIrq` is high.
- R8: `txDmaReq` is high when `dmaEnable[1]` is set and `txLevel` <= `txDmaThresh`. `rxDmaReq` is high when `dmaEnable[0]` is set and `rxLevel` > `rxDmaThresh`.
- R9: While `enable` is low, both levels become 0 at the next edge and pushes are ignored without setting overflow. Sticky flags keep their value.
- R10: `deepFifo` is 1 when DEPTH is 64 and 0 when DEPTH is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low flushes both queues |
| engBusy | input | 1 | Shift engine busy, shown in status bit 0 |
| busPush | input | 1 | Bus write strobe into the TX queue |
| busPushData | input | WIDTH | Word written by the bus |
| busPop | input | 1 | Bus read strobe from the RX queue |
| busPopData | output | WIDTH | Word read by the bus, zero if none delivered |
| engPush | input | 1 | Engine write strobe into the RX queue |
| engPushData | input | WIDTH | Word received by the engine |
| engPop | input | 1 | Engine read strobe from the TX queue |
| engPopData | output | WIDTH | Word delivered to the engine, zero if none |
| rxThresh | input | LW | RX interrupt threshold (trigger count minus one) |
| txDmaThresh | input | LW | TX DMA request level |
| rxDmaThresh | input | LW | RX DMA request level |
| intMask | input | 5 | Interrupt enable per source |
| clrWrite | input | 1 | Clear strobe |
| clrBits | input | 4 | Clear selection |
| dmaEnable | input | 2 | Bit 0 RX DMA, bit 1 TX DMA |
| txLevel | output | LW | TX queue occupancy |
| rxLevel | output | LW | RX queue occupancy |
| status | output | 5 | Status word |
| rawIrq | output | 5 | Unmasked interrupt sources |
| maskedIrq | output | 5 | Masked interrupt sources |
| irq | output | 1 | Interrupt line |
| txDmaReq | output | 1 | TX DMA request |
| rxDmaReq | output | 1 | RX DMA request |
| deepFifo | output | 1 | High when built with 64-word queues |

## Verification
Two events can meet in one cycle: a clear of the sticky flags and a new underflow. The bench provokes this by draining the receive queue and then raising the global clear and a bus pop of the empty queue together. It then expects the underflow bit to remain set while the other two sticky bits read zero. Received words flow through a scoreboard queue filled at each engine push and compared at each bus pop. This also shows that the overflow word pushed into a full queue never comes out.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // interrupt source positions
  localparam int IRQ_TX_EMPTY = 0;
  localparam int IRQ_TX_OVF   = 1;
  localparam int IRQ_RX_UDF   = 2;
  localparam int IRQ_RX_OVF   = 3;
  localparam int IRQ_RX_THR   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/spi_fifo_mem.sv
module spi_fifo_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wr,
  input  logic             rd,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wr) wrPtr <= wrPtr + 1'b1;
      if (rd) rdPtr <= rdPtr + 1'b1;
      level <= level + LW'(wr) - LW'(rd);
    end
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/spi_fifo_dpath.sv
module spi_fifo_dpath
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] busPushData,
  input  logic [WIDTH-1:0] engPushData,
  output logic [WIDTH-1:0] busPopData,
  output logic [WIDTH-1:0] engPopData,
  output logic [LW-1:0]    txLevel,
  output logic [LW-1:0]    rxLevel
);
  logic [WIDTH-1:0] txHead;
  logic [WIDTH-1:0] rxHead;

  spi_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .wr(strobe.txWr), .rd(strobe.txRd), .wrData(busPushData),
    .headData(txHead), .level(txLevel)
  );

  spi_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .wr(strobe.rxWr), .rd(strobe.rxRd), .wrData(engPushData),
    .headData(rxHead), .level(rxLevel)
  );

  // a pop that delivers nothing returns zero
  assign busPopData = strobe.rxRd ? rxHead : '0;
  assign engPopData = strobe.txRd ? txHead : '0;
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          engBusy,
  input  logic          busPush,
  input  logic          busPop,
  input  logic          engPush,
  input  logic          engPop,
  input  logic [LW-1:0] txLevel,
  input  logic [LW-1:0] rxLevel,
  input  logic [LW-1:0] rxThresh,
  input  logic [LW-1:0] txDmaThresh,
  input  logic [LW-1:0] rxDmaThresh,
  input  logic [4:0]    intMask,
  input  logic          clrWrite,
  input  logic [3:0]    clrBits,
  input  logic [1:0]    dmaEnable,
  output fifoStrobe_t   strobe,
  output logic [4:0]    status,
  output logic [4:0]    rawIrq,
  output logic [4:0]    maskedIrq,
  output logic          irq,
  output logic          txDmaReq,
  output logic          rxDmaReq
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txOvfEvt, rxOvfEvt, rxUdfEvt;
  logic clrAll;
  logic txOvf, rxOvf, rxUdf;

  assign txFull  = (txLevel == FULL_LVL);
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == FULL_LVL);
  assign rxEmpty = (rxLevel == '0);

  always_comb begin
    strobe.flush = !enable;
    strobe.txWr  = enable && busPush && !txFull;
    strobe.txRd  = enable && engPop && !txEmpty;
    strobe.rxWr  = enable && engPush && !rxFull;
    strobe.rxRd  = enable && busPop && !rxEmpty;
  end

  assign txOvfEvt = enable && busPush && txFull;
  assign rxOvfEvt = enable && engPush && rxFull;
  assign rxUdfEvt = busPop && !strobe.rxRd;
  assign clrAll   = clrWrite && clrBits[0];

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOvf <= 1'b0;
      rxOvf <= 1'b0;
      rxUdf <= 1'b0;
    end else begin
      txOvf <= txOvfEvt || (txOvf && !(clrAll || (clrWrite && clrBits[3])));
      rxOvf <= rxOvfEvt || (rxOvf && !(clrAll || (clrWrite && clrBits[2])));
      rxUdf <= rxUdfEvt || (rxUdf && !(clrAll || (clrWrite && clrBits[1])));
    end
  end

  always_comb begin
    rawIrq               = '0;
    rawIrq[IRQ_TX_EMPTY] = txEmpty;
    rawIrq[IRQ_TX_OVF]   = txOvf;
    rawIrq[IRQ_RX_UDF]   = rxUdf;
    rawIrq[IRQ_RX_OVF]   = rxOvf;
    rawIrq[IRQ_RX_THR]   = rxLevel > rxThresh;
  end

  assign maskedIrq = rawIrq & intMask;
  assign irq       = |maskedIrq;
  assign status    = {rxFull, rxEmpty, txEmpty, txFull, engBusy};
  assign txDmaReq  = dmaEnable[1] && (txLevel <= txDmaThresh);
  assign rxDmaReq  = dmaEnable[0] && (rxLevel > rxDmaThresh);
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             engBusy,
  input  logic             busPush,
  input  logic [WIDTH-1:0] busPushData,
  input  logic             busPop,
  output logic [WIDTH-1:0] busPopData,
  input  logic             engPush,
  input  logic [WIDTH-1:0] engPushData,
  input  logic             engPop,
  output logic [WIDTH-1:0] engPopData,
  input  logic [LW-1:0]    rxThresh,
  input  logic [LW-1:0]    txDmaThresh,
  input  logic [LW-1:0]    rxDmaThresh,
  input  logic [4:0]       intMask,
  input  logic             clrWrite,
  input  logic [3:0]       clrBits,
  input  logic [1:0]       dmaEnable,
  output logic [LW-1:0]    txLevel,
  output logic [LW-1:0]    rxLevel,
  output logic [4:0]       status,
  output logic [4:0]       rawIrq,
  output logic [4:0]       maskedIrq,
  output logic             irq,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             deepFifo
);
  fifoStrobe_t strobe;

  spi_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .engBusy(engBusy),
    .busPush(busPush), .busPop(busPop), .engPush(engPush), .engPop(engPop),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxThresh(rxThresh),
    .txDmaThresh(txDmaThresh), .rxDmaThresh(rxDmaThresh),
    .intMask(intMask), .clrWrite(clrWrite), .clrBits(clrBits),
    .dmaEnable(dmaEnable), .strobe(strobe), .status(status),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  spi_fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busPushData(busPushData), .engPushData(engPushData),
    .busPopData(busPopData), .engPopData(engPopData),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );

  assign deepFifo = (DEPTH == 64);
endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic          busPush,
  input logic          busPop,
  input logic          engPush,
  input logic          clrWrite,
  input logic [3:0]    clrBits,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel,
  input logic [4:0]    rawIrq
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LW'(DEPTH)) && (rxLevel <= LW'(DEPTH)));

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (int'(rxLevel) <= int'($past(rxLevel)) + 1));

  // R3
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && busPush && txLevel == LW'(DEPTH)) |=> (rawIrq[1] && txLevel <= LW'(DEPTH)));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawIrq[2] && !clrWrite) |=> rawIrq[2]);

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && clrBits[0] && !busPush && !engPush && !busPop) |=> (rawIrq[3:1] == 3'b000));

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txLevel == '0 && rxLevel == '0));
endmodule

bind spi_fifo_stat spi_fifo_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .busPush(busPush),
  .busPop(busPop), .engPush(engPush), .clrWrite(clrWrite),
  .clrBits(clrBits), .txLevel(txLevel), .rxLevel(rxLevel), .rawIrq(rawIrq)
);

// File: tb/test_spi_fifo_stat.sv
module test_spi_fifo_stat;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int WIDTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0;
  logic rstN = 0;
  logic enable = 0, engBusy = 0;
  logic busPush = 0, busPop = 0, engPush = 0, engPop = 0;
  logic [WIDTH-1:0] busPushData = '0, engPushData = '0;
  logic [WIDTH-1:0] busPopData, engPopData;
  logic [LW-1:0] rxThresh = '0, txDmaThresh = '0, rxDmaThresh = '0;
  logic [4:0] intMask = '0;
  logic clrWrite = 0;
  logic [3:0] clrBits = '0;
  logic [1:0] dmaEnable = '0;
  logic [LW-1:0] txLevel, rxLevel;
  logic [4:0] status, rawIrq, maskedIrq;
  logic irq, txDmaReq, rxDmaReq, deepFifo;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  logic [WIDTH-1:0] rxQ[$];
  logic [WIDTH-1:0] txQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_stat #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_spi_fifo_stat (.*);

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver: engine pushes a word, expected item enters the scoreboard
  task automatic engPushWord(logic [WIDTH-1:0] d, bit expectKept);
    engPush = 1; engPushData = d;
    if (expectKept) rxQ.push_back(d);
    tick();
    engPush = 0;
  endtask

  task automatic busPushWord(logic [WIDTH-1:0] d, bit expectKept);
    busPush = 1; busPushData = d;
    if (expectKept) txQ.push_back(d);
    tick();
    busPush = 0;
  endtask

  // monitor: bus pop compared against the scoreboard head (zero if empty)
  task automatic busPopWord();
    logic [WIDTH-1:0] exp;
    busPop = 1;
    #1;
    exp = (rxQ.size() > 0) ? rxQ.pop_front() : '0;
    chk("R2/R4 rx data", int'(busPopData), int'(exp));
    tick();
    busPop = 0;
  endtask

  task automatic engPopWord();
    logic [WIDTH-1:0] exp;
    engPop = 1;
    #1;
    exp = (txQ.size() > 0) ? txQ.pop_front() : '0;
    chk("R2 tx data", int'(engPopData), int'(exp));
    tick();
    engPop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    // R1 reset state
    chk("R1 txLevel", int'(txLevel), 0);
    chk("R1 rxLevel", int'(rxLevel), 0);
    chk("R1 status", int'(status), 5'b01100);
    chk("R1 rawIrq", int'(rawIrq), 5'b00001);
    chk("R10 deepFifo", int'(deepFifo), 0);
    enable = 1;
    engBusy = 1;
    tick();
    chk("R1 busy bit", int'(status[0]), 1);
    engBusy = 0;

    // RX words and threshold
    engPushWord(16'h00A1, 1);
    engPushWord(16'h00B2, 1);
    engPushWord(16'h00C3, 1);
    chk("R2 rxLevel", int'(rxLevel), 3);
    rxThresh = 2; #1;
    chk("R5 rx thresh above", int'(rawIrq[4]), 1);
    rxThresh = 3; #1;
    chk("R5 rx thresh equal", int'(rawIrq[4]), 0);
    for (int i = 0; i < 3; i++) busPopWord();
    // pop from empty RX
    busPopWord();
    chk("R4 underflow set", int'(rawIrq[2]), 1);
    tick();
    chk("R6 sticky hold", int'(rawIrq[2]), 1);
    clrWrite = 1; clrBits = 4'b0010;
    tick();
    clrWrite = 0; clrBits = '0;
    chk("R6 clear underflow", int'(rawIrq[2]), 0);

    // TX fill, overflow, DMA
    txDmaThresh = 16; dmaEnable = 2'b10; #1;
    chk("R8 tx dma at empty", int'(txDmaReq), 1);
    for (int i = 0; i < DEPTH; i++) busPushWord(WIDTH'(i * 3 + 5), 1);
    chk("R2 txLevel full", int'(txLevel), DEPTH);
    chk("R1 tx full bit", int'(status[2:1]), 2'b01);
    chk("R8 tx dma off when full", int'(txDmaReq), 0);
    busPushWord(16'hDEAD, 0);
    chk("R3 tx overflow", int'(rawIrq[1]), 1);
    chk("R3 level kept", int'(txLevel), DEPTH);
    for (int i = 0; i < 16; i++) engPopWord();
    chk("R8 tx dma at thresh", int'(txDmaReq), 1);
    for (int i = 0; i < 16; i++) engPopWord();
    chk("R5 tx empty irq", int'(rawIrq[0]), 1);

    // RX overflow and DMA
    rxDmaThresh = 3; dmaEnable = 2'b01;
    for (int i = 0; i < DEPTH; i++) engPushWord(WIDTH'(16'h100 + i), 1);
    chk("R1 rx full bit", int'(status[4:3]), 2'b10);
    chk("R8 rx dma on", int'(rxDmaReq), 1);
    engPushWord(16'hBEEF, 0);
    chk("R4 rx overflow", int'(rawIrq[3]), 1);
    chk("R4 rx level kept", int'(rxLevel), DEPTH);
    for (int i = 0; i < DEPTH - 3; i++) busPopWord();
    chk("R8 rx dma off at thresh", int'(rxDmaReq), 0);
    busPopWord(); busPopWord();
    chk("R2 rxLevel one", int'(rxLevel), 1);

    // masking
    intMask = 5'b01000; #1;
    chk("R7 raw", int'(rawIrq), 5'b01011);
    chk("R7 masked", int'(maskedIrq), 5'b01000);
    chk("R7 irq on", int'(irq), 1);
    intMask = 5'b00100; #1;
    chk("R7 irq off", int'(irq), 0);

    // clear and new underflow in the same cycle
    busPopWord();
    clrWrite = 1; clrBits = 4'b0001; busPop = 1;
    tick();
    clrWrite = 0; clrBits = '0; busPop = 0;
    chk("R6 set wins", int'(rawIrq[3:1]), 3'b010);
    clrWrite = 1; clrBits = 4'b0001;
    tick();
    clrWrite = 0; clrBits = '0;
    chk("R6 clear all", int'(rawIrq[3:1]), 3'b000);

    // disable flush
    engPushWord(16'h0001, 0);
    engPushWord(16'h0002, 0);
    busPushWord(16'h0003, 0);
    busPop = 1; busPop = 0;
    enable = 0;
    tick();
    chk("R9 tx flushed", int'(txLevel), 0);
    chk("R9 rx flushed", int'(rxLevel), 0);
    engPushWord(16'h0004, 0);
    busPushWord(16'h0005, 0);
    chk("R9 push ignored", int'(rxLevel) + int'(txLevel), 0);
    chk("R9 no overflow", int'(rawIrq[3:1]), 0);
    enable = 1;
    tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule